// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block produces and verifies the even parity bit for a 32-bit multiplexed address/data bus that carries a 4-bit command/byte-enable field beside it. The parity bit, together with its drive enable, is launched one bus clock after the phase it protects. The surrounding bus controller supplies the sampled bus values, the address and data phase strobes, and whether the local agent is the initiator or the target and whether the transfer is a write or a read.

During a data phase in which the block is the target of a write, it registers the computed parity. It then compares that value with the parity bit received on the bus in the following clock. A mismatch sets a sticky status bit, which is cleared by a write-one strobe. If the matching enable is set, the mismatch also raises a one-clock event toward a non-maskable or a system-management interrupt request.

Top module: `bus_parity`

## Requirements
- R1: `par_out` makes the number of ones across `ad`, `cbe` and `par_out` even, where `ad` and `cbe` are the values sampled in the last phase strobe.
- R2: All four `cbe` bits enter the parity whatever their value, including all-ones (every byte lane inactive, active-low).
- R3: `par_out` takes the new parity in the clock after a cycle with `addr_phase` or `data_phase` high, and holds it while both strobes stay low, whatever `ad` and `cbe` do.
- R4: `par_oe` is high in the clock after an address phase with `is_initiator`=1, low after an address phase with `is_initiator`=0, and low in the clock after any cycle with no phase strobe.
- R5: After a data phase without an address strobe, `par_oe` is high only when `is_initiator`=1 with `is_write`=1, or `is_initiator`=0 with `is_write`=0.
- R6: After a data phase with `is_initiator`=0 and `is_write`=1, a `par_in` in the next clock that differs from the expected parity sets `perr_sts` one clock later. A `par_in` mismatch after any other phase kind has no effect.
- R7: `perr_sts` stays set until a clock where `sts_clr`=1 and no new error is detected. A new error in the same clock as the clear leaves it set.
- R8: On a detected error, `nmi_evt` (when `nmi_en`=1 in the compare clock) and `smi_evt` (when `smi_en`=1) go high for exactly one clock, at the same time as `perr_sts` becomes set.
- R9: While `rst_n`=0, `par_out`, `par_oe`, `perr_sts`, `nmi_evt` and `smi_evt` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad | input | 32 | Sampled address/data bus |
| cbe | input | 4 | Sampled command/byte-enable field |
| addr_phase | input | 1 | Address phase in this clock |
| data_phase | input | 1 | Data phase completes in this clock |
| is_initiator | input | 1 | 1 when the local agent is the initiator, 0 when it is the target |
| is_write | input | 1 | 1 for a write transfer, 0 for a read |
| par_in | input | 1 | Parity bit sampled from the bus |
| nmi_en | input | 1 | Enables the NMI event on a parity error |
| smi_en | input | 1 | Enables the SMI event on a parity error |
| sts_clr | input | 1 | Write-one clear of the error status |
| par_out | output | 1 | Parity bit to drive |
| par_oe | output | 1 | Parity drive enable |
| perr_sts | output | 1 | Sticky parity error status |
| nmi_evt | output | 1 | One-clock NMI request pulse |
| smi_evt | output | 1 | One-clock SMI request pulse |

## Verification
Random bus words and fields are mixed with fixed words of zero, all ones, a single one and all-inactive byte enables. The fixed words separate a correct 36-bit reduction from one that drops or masks the `cbe` bits. Each of the four role/direction pairs is run in both address and data phases, with and without a corrupted `par_in`. This shows that parity is driven and checked only for the correct combinations. Clears that coincide with a new error, and errors left uncleared, separate set-over-clear priority and stickiness from a plain one-cycle flag.

// File: rtl/bus_parity.sv
module bus_parity #(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AD_W-1:0]  ad,
  input  logic [CBE_W-1:0] cbe,
  input  logic             addr_phase,
  input  logic             data_phase,
  input  logic             is_initiator,
  input  logic             is_write,
  input  logic             par_in,
  input  logic             nmi_en,
  input  logic             smi_en,
  input  logic             sts_clr,
  output logic             par_out,
  output logic             par_oe,
  output logic             perr_sts,
  output logic             nmi_evt,
  output logic             smi_evt
);
  localparam int PW = AD_W + CBE_W;

  logic [PW-1:0] bits;
  logic phase, drive, check, chk_q, mismatch;

  assign bits  = {cbe, ad};
  assign phase = addr_phase | data_phase;
  assign drive = (addr_phase & is_initiator) | (data_phase & (is_initiator ~^ is_write));
  assign check = data_phase & ~addr_phase & ~is_initiator & is_write;
  assign mismatch = chk_q & (par_in != par_out);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_out  <= 1'b0;
      par_oe   <= 1'b0;
      chk_q    <= 1'b0;
      perr_sts <= 1'b0;
      nmi_evt  <= 1'b0;
      smi_evt  <= 1'b0;
    end else begin
      if (phase) par_out <= ^bits;
      par_oe  <= drive;
      chk_q   <= check;
      nmi_evt <= mismatch & nmi_en;
      smi_evt <= mismatch & smi_en;
      if (mismatch)     perr_sts <= 1'b1;
      else if (sts_clr) perr_sts <= 1'b0;
    end
  end
endmodule

// File: rtl/bus_parity_chk.sv
module bus_parity_chk #(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AD_W-1:0]  ad,
  input logic [CBE_W-1:0] cbe,
  input logic             addr_phase,
  input logic             data_phase,
  input logic             is_initiator,
  input logic             is_write,
  input logic             par_in,
  input logic             nmi_en,
  input logic             smi_en,
  input logic             sts_clr,
  input logic             par_out,
  input logic             par_oe,
  input logic             perr_sts,
  input logic             nmi_evt,
  input logic             smi_evt
);
  assert_even_parity_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_phase | data_phase) |=> ((^{$past(cbe), $past(ad)}) == par_out));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_phase && !data_phase) |=> $stable(par_out));

  assert_addr_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_phase && is_initiator) |=> par_oe);

  assert_idle_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_phase && !data_phase) |=> !par_oe);

  assert_data_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_phase && !addr_phase) |=> (par_oe == ($past(is_initiator) == $past(is_write))));

  assert_detect_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_phase && !addr_phase && !is_initiator && is_write) ##1 (par_in != par_out) |=> perr_sts);

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_sts && !sts_clr) |=> perr_sts);

  assert_nmi_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_evt |-> perr_sts);

  assert_smi_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    smi_evt |-> $past(smi_en));

  assert_reset_quiet_R9: assert property (@(posedge clk)
    !rst_n |=> (!par_oe && !perr_sts && !nmi_evt && !smi_evt));
endmodule

bind bus_parity bus_parity_chk #(.AD_W(AD_W), .CBE_W(CBE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ad(ad), .cbe(cbe), .addr_phase(addr_phase),
  .data_phase(data_phase), .is_initiator(is_initiator), .is_write(is_write),
  .par_in(par_in), .nmi_en(nmi_en), .smi_en(smi_en), .sts_clr(sts_clr),
  .par_out(par_out), .par_oe(par_oe), .perr_sts(perr_sts),
  .nmi_evt(nmi_evt), .smi_evt(smi_evt));

// File: tb/bus_parity_test.sv
module bus_parity_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] ad = '0;
  logic [3:0]  cbe = '0;
  logic addr_phase = 0, data_phase = 0, is_initiator = 0, is_write = 0;
  logic par_in = 0, nmi_en = 0, smi_en = 0, sts_clr = 0;
  logic par_out, par_oe, perr_sts, nmi_evt, smi_evt;
  int checks = 0, fails = 0;
  bit st = 0, done = 0;

  always #5 clk = ~clk;

  bus_parity uut (.*);

  function automatic bit exp_par(input logic [31:0] a, input logic [3:0] c);
    int n = 0;
    for (int i = 0; i < 32; i++) n += a[i];
    for (int i = 0; i < 4; i++) n += c[i];
    return bit'(n % 2);
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic txn(input logic [31:0] a, input logic [3:0] c, input bit is_addr,
                     input bit init, input bit wr, input bit bad, input bit ne,
                     input bit se, input bit clr_early, input bit keep);
    bit p, oe, chkd, err;
    p    = exp_par(a, c);
    oe   = is_addr ? init : (init == wr);
    chkd = !is_addr && !init && wr;
    err  = chkd && bad;
    @(negedge clk);
    ad = a; cbe = c; addr_phase = is_addr; data_phase = !is_addr;
    is_initiator = init; is_write = wr;
    @(negedge clk);
    addr_phase = 0; data_phase = 0;
    ad = $urandom; cbe = 4'($urandom);
    par_in = bad ? !p : p; nmi_en = ne; smi_en = se; sts_clr = clr_early;
    chk("R1 parity", par_out, p);
    chk(is_addr ? "R4 addr drive" : "R5 data drive", par_oe, oe);
    if (err) st = 1; else if (clr_early) st = 0;
    @(negedge clk);
    par_in = $urandom; sts_clr = !keep;
    chk("R3 hold", par_out, p);
    chk("R4 idle release", par_oe, 1'b0);
    chk("R6 detect", perr_sts, st);
    chk("R8 nmi", nmi_evt, err && ne);
    chk("R8 smi", smi_evt, err && se);
    if (!keep) st = 0;
    @(negedge clk);
    sts_clr = 0;
    chk("R7 status", perr_sts, st);
    chk("R8 nmi one clock", nmi_evt, 1'b0);
    chk("R8 smi one clock", smi_evt, 1'b0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    ad = 32'hFFFF_FFFF; cbe = 4'hF; addr_phase = 1; is_initiator = 1;
    repeat (3) @(negedge clk);
    chk("R9 reset par_out", par_out, 1'b0);
    chk("R9 reset par_oe", par_oe, 1'b0);
    chk("R9 reset sts", perr_sts, 1'b0);
    chk("R9 reset nmi", nmi_evt, 1'b0);
    chk("R9 reset smi", smi_evt, 1'b0);
    addr_phase = 0; is_initiator = 0;
    rst_n = 1;
    // directed words, including all byte lanes inactive (R2)
    txn(32'h0, 4'h0, 1, 1, 1, 0, 0, 0, 0, 0);
    txn(32'hFFFF_FFFF, 4'hF, 1, 1, 0, 0, 0, 0, 0, 0);
    txn(32'h1, 4'h0, 1, 0, 1, 0, 0, 0, 0, 0);
    txn(32'h0, 4'hF, 0, 1, 1, 0, 0, 0, 0, 0);
    txn(32'h0, 4'h7, 0, 0, 0, 0, 0, 0, 0, 0);
    txn(32'h8000_0000, 4'h8, 0, 0, 1, 0, 0, 0, 0, 0);
    // mismatches outside target write are ignored (R6)
    txn(32'h1234_5678, 4'h3, 0, 1, 1, 1, 1, 1, 0, 0);
    txn(32'h1234_5678, 4'h3, 0, 0, 0, 1, 1, 1, 0, 0);
    txn(32'h1234_5678, 4'h3, 1, 0, 1, 1, 1, 1, 0, 0);
    // error with both events, then stickiness and set-over-clear (R7)
    txn(32'hDEAD_BEEF, 4'hA, 0, 0, 1, 1, 1, 1, 0, 1);
    txn(32'h0F0F_0F0F, 4'h5, 0, 0, 1, 0, 0, 0, 0, 1);
    txn(32'h0F0F_0F0F, 4'h5, 0, 0, 1, 1, 1, 0, 1, 0);
    txn(32'h0000_00FF, 4'h1, 0, 0, 1, 1, 0, 1, 0, 0);
    // clear with no new error (R7)
    txn(32'hCAFE_0001, 4'h2, 0, 0, 1, 1, 0, 0, 0, 1);
    txn(32'hCAFE_0001, 4'h2, 0, 1, 0, 0, 0, 0, 1, 0);
    for (int i = 0; i < 300; i++)
      txn($urandom, 4'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
          1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 4) == 0,
          ($urandom % 3) == 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule